// File: doc/BRIEF.md
# Video Memory Write Port

This block is the processor-facing path for putting words into video memory. The processor first writes a destination address to one register index, then writes data words to a second register index. Each data word lands in a buffer one word deep. The memory side drains that word through a valid/ready handshake. The buffer never stalls the processor: a data write that finds the buffer still occupied replaces the waiting word and raises a sticky overwrite flag.

The upper byte of the destination address picks one of two memory regions. The lower byte gives a word-aligned offset into that region. Each word the memory side accepts advances the offset by one word. A destination address with an unknown region code parks the port, and the port issues no requests until a good address arrives. A status read gives the buffer-full and overwrite flags.

Back-pressure rules on the memory stream: `mem_valid` rises when a word is waiting and a valid address is loaded. A transfer happens on every rising clock edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the word, its offset and its region are held unchanged. The only exceptions are a processor data write, which replaces the word, and an address write, which drops it.

Top module: `vram_wport`

## Requirements
- R1: After reset `mem_valid` is 0, a status read returns 0, and no address is loaded, so the port issues no request.
- R2: A write to register index 0xE loads the destination address and discards any waiting word. Address bits [15:8] select the region: 0x7E gives `mem_sel`=0 and 0x7F gives `mem_sel`=1. Bits [7:0] give the offset with bit 0 forced to 0.
- R3: After an address write whose bits [15:8] are neither 0x7E nor 0x7F, `mem_valid` stays 0 until a valid address is written. Data writes still fill the buffer.
- R4: A write to register index 0xF stores the word and sets buffer-full. `mem_valid` is high while the buffer is full and a valid address is loaded.
- R5: A data write while the buffer is full, with no transfer in that cycle, replaces the waiting word. Only the newest word is delivered, and the overwrite flag sets.
- R6: Each transfer empties the buffer on that edge and advances the offset by 2, wrapping modulo 256 within the same region.
- R7: Data writes do not move the offset. Only a transfer advances it.
- R8: A read of index 0xE returns bit 0 = buffer-full and bit 1 = overwrite flag in the same cycle, with all other bits 0. A read of any other index returns 0.
- R9: The overwrite flag clears on the edge that ends a status read.
- R10: A data write in the same cycle as a transfer delivers the old word, keeps the new one waiting, and does not set the overwrite flag.
- R11: While `mem_valid` is high and `mem_ready` low, and the processor writes nothing, `mem_valid`, `mem_data`, `mem_offset` and `mem_sel` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 4 | Register index of the processor access |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data (status) |
| mem_valid | output | 1 | A word is offered to video memory |
| mem_ready | input | 1 | Memory side grant; accepts the word |
| mem_sel | output | 1 | Region of the offered word (0: code 0x7E, 1: code 0x7F) |
| mem_offset | output | 8 | Word-aligned offset of the offered word |
| mem_data | output | 16 | Offered word |

## Verification
A processor data write and a memory-side grant can fall on the same clock edge. The old word must then leave and the new one stay, with no overwrite flagged. The bench provokes this by holding a word with `mem_ready` low, then raising `mem_ready` in the same cycle as the next data write. The scoreboard then expects both words at consecutive offsets, in order, and the status read that follows must show neither full nor overwrite.

// File: rtl/vwp_pkg.sv
package vwp_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned KIND_W = DATA_W - OFS_W;

  localparam logic [SEL_W-1:0]  IDX_ADDR = 4'hE;
  localparam logic [SEL_W-1:0]  IDX_DATA = 4'hF;
  localparam logic [KIND_W-1:0] CODE_R0  = 8'h7E;
  localparam logic [KIND_W-1:0] CODE_R1  = 8'h7F;

  typedef enum logic { REGION_0 = 1'b0, REGION_1 = 1'b1 } region_e;

  typedef struct packed {
    logic ovf;
    logic full;
  } stat_t;
endpackage

// File: rtl/vwp_addr_reg.sv
module vwp_addr_reg
  import vwp_pkg::*;
#(
  parameter int unsigned AW  = DATA_W,
  parameter int unsigned OW  = OFS_W,
  parameter logic [AW-OW-1:0] C0 = CODE_R0,
  parameter logic [AW-OW-1:0] C1 = CODE_R1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic          enabled,
  output region_e       region,
  output logic [OW-1:0] offset
);
  localparam int unsigned KW = AW - OW;
  localparam logic [OW-1:0] WORD_STEP = OW'(2);
  localparam logic [OW-1:0] ALIGN_MASK = ~OW'(1);

  logic [KW-1:0] code_in;
  logic          code_ok;

  assign code_in = load_addr[AW-1:OW];
  assign code_ok = (code_in == C0) || (code_in == C1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      region  <= REGION_0;
      offset  <= '0;
    end else if (load) begin
      enabled <= code_ok;
      region  <= (code_in == C1) ? REGION_1 : REGION_0;
      offset  <= load_addr[OW-1:0] & ALIGN_MASK;
    end else if (step) begin
      offset  <= offset + WORD_STEP;
    end
  end

  // R6: each accepted word moves the offset by one word, wrapping
  a_r6_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (offset == $past(offset) + WORD_STEP));

  // R2: offset stays word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (offset[0] == 1'b0));

  // R3: a bad region code parks the port
  a_r3_park: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !code_ok) |=> !enabled);
endmodule

// File: rtl/vwp_word_buf.sv
module vwp_word_buf
  import vwp_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          flush,
  input  logic          take,
  input  logic          clr_ovf,
  output logic          full,
  output logic          ovf,
  output logic [DW-1:0] word
);
  logic clobber;

  assign clobber = push && full && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (push)
        word <= push_data;
      if (flush)
        full <= 1'b0;
      else if (push)
        full <= 1'b1;
      else if (take)
        full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf <= 1'b0;
    else if (clobber)
      ovf <= 1'b1;
    else if (clr_ovf)
      ovf <= 1'b0;
  end

  // R5: replacing a waiting word raises the flag
  a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !take) |=> (ovf && full));

  // R10: push together with a take is not an overwrite
  a_r10_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && take && !ovf) |=> (!ovf && full));

  // R9: a status read clears the flag unless a new overwrite lands
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(push && full && !take)) |=> !ovf);

  // R6: a take without push empties the buffer
  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !push) |=> !full);
endmodule

// File: rtl/vwp_status.sv
module vwp_status
  import vwp_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          rd_stat,
  input  stat_t         stat,
  output logic [DW-1:0] rdata
);
  localparam int unsigned SW = $bits(stat_t);

  always_comb begin
    rdata = '0;
    if (rd_stat)
      rdata[SW-1:0] = stat;
  end
endmodule

// File: rtl/vram_wport.sv
module vram_wport
  import vwp_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SW = SEL_W,
  parameter logic [SW-1:0] ADDR_IDX = IDX_ADDR,
  parameter logic [SW-1:0] DATA_IDX = IDX_DATA,
  parameter logic [DW-OW-1:0] REGION0_CODE = CODE_R0,
  parameter logic [DW-OW-1:0] REGION1_CODE = CODE_R1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cpu_sel,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_sel,
  output logic [OW-1:0] mem_offset,
  output logic [DW-1:0] mem_data
);
  logic    ld_addr;
  logic    push_word;
  logic    rd_stat;
  logic    take;
  logic    addr_en;
  logic    buf_full;
  logic    buf_ovf;
  region_e region;
  stat_t   stat;

  assign ld_addr   = cpu_wr && (cpu_sel == ADDR_IDX);
  assign push_word = cpu_wr && (cpu_sel == DATA_IDX);
  assign rd_stat   = cpu_rd && (cpu_sel == ADDR_IDX);
  assign mem_valid = buf_full && addr_en;
  assign take      = mem_valid && mem_ready;
  assign mem_sel   = (region == REGION_1);
  assign stat      = '{ovf: buf_ovf, full: buf_full};

  vwp_addr_reg #(
    .AW(DW), .OW(OW), .C0(REGION0_CODE), .C1(REGION1_CODE)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(ld_addr), .load_addr(cpu_wdata), .step(take),
    .enabled(addr_en), .region(region), .offset(mem_offset)
  );

  vwp_word_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(push_word), .push_data(cpu_wdata), .flush(ld_addr),
    .take(take), .clr_ovf(rd_stat),
    .full(buf_full), .ovf(buf_ovf), .word(mem_data)
  );

  vwp_status #(.DW(DW)) u_stat (
    .rd_stat(rd_stat), .stat(stat), .rdata(cpu_rdata)
  );

  // R11: offered word held under back-pressure
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cpu_wr) |=>
      (mem_valid && $stable(mem_data) && $stable(mem_offset) && $stable(mem_sel)));

  // R2: an address write drops any waiting word
  a_r2_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ld_addr |=> !mem_valid);

  // R8: reads of other indices return zero
  a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |-> (cpu_rdata == '0));
endmodule

// File: tb/vram_wport_tb.sv
module vram_wport_tb;
  typedef struct {
    logic        sel;
    logic [7:0]  ofs;
    logic [15:0] data;
    string       req;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cpu_sel = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_sel;
  logic [7:0]  mem_offset;
  logic [15:0] mem_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  xfer_t sb[$];

  always #4 clk = ~clk;

  vram_wport u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_sel(mem_sel),
    .mem_offset(mem_offset), .mem_data(mem_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: handshake seen mid-cycle completes at the next edge
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected transfer actual=%h@%h expected=none", mem_data, mem_offset);
      end else begin
        xfer_t e;
        e = sb.pop_front();
        check(e.req, {7'd0, mem_sel, mem_offset, mem_data}, {7'd0, e.sel, e.ofs, e.data});
      end
    end
  end

  task automatic expect_xfer(input logic s, input logic [7:0] o, input logic [15:0] d, input string req);
    xfer_t e;
    e.sel = s; e.ofs = o; e.data = d; e.req = req;
    sb.push_back(e);
  endtask

  task automatic cpu_write(input logic [3:0] sel, input logic [15:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic read_status(input logic [15:0] exp, input string req);
    cpu_sel = 4'hE; cpu_rd = 1'b1;
    #2;
    check(req, {16'd0, cpu_rdata}, {16'd0, exp});
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 valid", {31'd0, mem_valid}, 32'd0);
    read_status(16'h0000, "R1 status");

    // R3 bad region code: buffer fills but no request
    mem_ready = 1'b1;
    cpu_write(4'hE, 16'h1234);
    cpu_write(4'hF, 16'hAAAA);
    idle(3);
    check("R3 no request", {31'd0, mem_valid}, 32'd0);
    read_status(16'h0001, "R4 full while parked");
    // R8 other index reads zero
    cpu_sel = 4'h3; cpu_rd = 1'b1; #2;
    check("R8 other index", {16'd0, cpu_rdata}, 32'd0);
    @(posedge clk); #1; cpu_rd = 1'b0;
    // R2 address write discards the waiting word
    cpu_write(4'hE, 16'h7E10);
    check("R2 discard", {31'd0, mem_valid}, 32'd0);
    read_status(16'h0000, "R2 discard status");

    // R6 consecutive words advance offset
    expect_xfer(1'b0, 8'h10, 16'h1111, "R6 first");
    cpu_write(4'hF, 16'h1111);
    idle(2);
    expect_xfer(1'b0, 8'h12, 16'h2222, "R6 second");
    cpu_write(4'hF, 16'h2222);
    idle(2);

    // R2 region 1, bit 0 ignored
    cpu_write(4'hE, 16'h7F11);
    expect_xfer(1'b1, 8'h10, 16'h3333, "R2 region1 aligned");
    cpu_write(4'hF, 16'h3333);
    idle(2);

    // R5 overwrite, R7 offset untouched, R11 hold, R9 clear
    mem_ready = 1'b0;
    cpu_write(4'hE, 16'h7E40);
    cpu_write(4'hF, 16'hB0B0);
    cpu_write(4'hF, 16'hC0C0);
    idle(3);
    check("R11 held valid", {31'd0, mem_valid}, 32'd1);
    check("R7 offset", {24'd0, mem_offset}, {24'd0, 8'h40});
    check("R5 newest word", {16'd0, mem_data}, {16'd0, 16'hC0C0});
    read_status(16'h0003, "R5 overwrite flag");
    read_status(16'h0001, "R9 flag cleared");
    expect_xfer(1'b0, 8'h40, 16'hC0C0, "R5 only newest");
    mem_ready = 1'b1;
    idle(2);

    // R6 wrap
    cpu_write(4'hE, 16'h7EFE);
    expect_xfer(1'b0, 8'hFE, 16'hD001, "R6 top");
    cpu_write(4'hF, 16'hD001);
    idle(2);
    expect_xfer(1'b0, 8'h00, 16'hD002, "R6 wrap");
    cpu_write(4'hF, 16'hD002);
    idle(2);

    // R10 data write coincides with transfer
    mem_ready = 1'b0;
    cpu_write(4'hE, 16'h7E20);
    cpu_write(4'hF, 16'h5151);
    expect_xfer(1'b0, 8'h20, 16'h5151, "R10 old word");
    expect_xfer(1'b0, 8'h22, 16'h5252, "R10 new word");
    mem_ready = 1'b1;
    cpu_write(4'hF, 16'h5252);
    idle(2);
    mem_ready = 1'b0;
    read_status(16'h0000, "R10 no overwrite");

    check("scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule